// File: doc/BRIEF.md
# Watchdog Reset Generator

This block is a free-running supervision timer that pulls the system into reset when software stops servicing it. A prescaler running on the oscillator clock produces one tick each time it wraps, and those ticks advance a small watchdog counter. When the counter finishes its terminal count, the block drives an active-low reset output for a fixed number of clocks and sets a sticky cause flag that software can read after the restart.

Software services the timer by writing any value to one bus address. That address also serves as the low byte of the CPU reset vector, so a read there returns a byte supplied from outside the block and has no effect on the timer. A static disable input turns the supervision off. A stop-mode input freezes the watchdog count and clears the prescaler. While stop is low the timer keeps running in every other CPU state, so software has to keep servicing it during idle or wait periods.

Top module: `wdog_guard`

## Requirements
- R1: The prescaler (PRE_W bits, default 13) advances on every clock when stop_i is low. It produces one tick when it wraps from all ones to zero, which happens every 2^PRE_W clocks. Each tick advances the watchdog counter (CNT_W bits, default 6) by one.
- R2: With no service and no internal reset, wd_rst_n_o goes low at the clock edge that completes TERM ticks (default 32). After por_i or rst_i is released this is TERM·2^PRE_W clocks, which is 262144 clocks at the default settings.
- R3: A write strobe with bus_addr_i equal to SVC_ADDR (default 16'hFFFF) clears the watchdog counter. It also clears prescaler bits PRE_W-1 down to CLR_LSB (default 12..4), while the bits below CLR_LSB keep counting. A write to any other address has no effect.
- R4: A read strobe at SVC_ADDR puts vec_lo_i on rd_data_o one clock later. Any other read gives 0 there. No read changes the timeout timing.
- R5: A timeout holds wd_rst_n_o low for exactly RST_LEN clocks (default 32), starting the clock after the timeout edge.
- R6: A timeout sets wd_flag_o. The flag stays set until por_i or a stat_clr_i pulse clears it, and a timeout in the same clock as stat_clr_i wins.
- R7: While wd_dis_i is 1 the watchdog counter holds its value and no timeout occurs. When wd_dis_i is 0 the watchdog is enabled.
- R8: While stop_i is 1 the prescaler is held at zero and the watchdog counter keeps its value. Counting resumes from that value once stop_i returns to 0.
- R9: rst_i clears the prescaler, the watchdog counter and rd_data_o, but leaves wd_flag_o and any running reset pulse alone. por_i clears everything, after which wd_rst_n_o is 1 and wd_flag_o is 0.
- R10: A service write in the same clock as the final tick prevents the timeout, and wd_rst_n_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| rst_i | input | 1 | Global internal reset, synchronous, active high |
| wd_dis_i | input | 1 | Static watchdog disable (1 = off) |
| stop_i | input | 1 | Stop mode: freezes the count, clears the prescaler |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| vec_lo_i | input | DATA_W | Reset-vector low byte returned on reads |
| rd_data_o | output | DATA_W | Registered read data |
| stat_clr_i | input | 1 | Clears the timeout cause flag |
| wd_rst_n_o | output | 1 | Watchdog reset output, active low |
| wd_flag_o | output | 1 | Sticky watchdog-reset cause flag |

## Verification
On every clock the assertions check several cycle-local rules: that a service write empties the counter, that disable and stop each freeze it, that stop zeroes the prescaler, that the reset pulse length is exact, that the flag rises with the pulse, and that a service write never lets the output fall. The bench scenarios are needed for the behaviour that spans long windows. This covers the exact distance from reset or service to the timeout edge, resuming after stop at the held count, the flag surviving rst_i, the reads leaving the timing untouched, and the final-tick race against a service write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // decoded bus activity for one clock
  typedef struct packed {
    logic svc;   // service write hit
    logic rd;    // vector-byte read hit
  } bus_evt_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/wdog_bus_decode.sv
module wdog_bus_decode
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
  input  logic              clk_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] vec_lo_i,
  output bus_evt_t          evt_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              hit;
  logic [DATA_W-1:0] rd_q;

  assign hit       = (addr_i == SVC_ADDR);
  assign evt_o.svc = wr_i & hit;
  assign evt_o.rd  = rd_i & hit;

  always_ff @(posedge clk_i) begin
    if (clr_i)         rd_q <= '0;
    else if (evt_o.rd) rd_q <= vec_lo_i;
    else               rd_q <= '0;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W   = 13,
  parameter int CLR_LSB = 4
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             stop_i,
  input  logic             svc_i,
  output logic             tick_o,
  output logic [PRE_W-1:0] pre_o
);
  localparam logic [PRE_W-1:0] ALL1 = '1;
  logic [PRE_W-1:0] pre_q, inc, keep;

  // mask of the low bits that survive a service write
  generate
    if (CLR_LSB <= 0) begin : g_full_clear
      assign keep = '0;
    end else if (CLR_LSB >= PRE_W) begin : g_no_clear
      assign keep = '1;
    end else begin : g_part_clear
      assign keep = {{(PRE_W-CLR_LSB){1'b0}}, {CLR_LSB{1'b1}}};
    end
  endgenerate

  assign inc = pre_q + PRE_W'(1);

  always_ff @(posedge clk_i) begin
    if (clr_i || stop_i) pre_q <= '0;
    else if (svc_i)      pre_q <= inc & keep;
    else                 pre_q <= inc;
  end

  assign tick_o = ~stop_i & (pre_q == ALL1);
  assign pre_o  = pre_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 6,
  parameter int TERM  = 32
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             svc_i,
  input  logic             tick_i,
  input  logic             dis_i,
  output logic             timeout_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM - 1);
  logic [CNT_W-1:0] cnt_q;
  logic             adv, fin;

  assign adv       = tick_i & ~dis_i;
  assign fin       = adv & (cnt_q == LAST);
  assign timeout_o = fin & ~svc_i;

  always_ff @(posedge clk_i) begin
    if (clr_i || svc_i) cnt_q <= '0;
    else if (fin)       cnt_q <= '0;
    else if (adv)       cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse
  import wdog_pkg::*;
#(
  parameter int RST_LEN = 32
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic fire_i,
  input  logic stat_clr_i,
  output logic rst_n_o,
  output logic flag_o
);
  localparam int RW = cnt_width(RST_LEN);
  localparam logic [RW-1:0] LEN = RW'(RST_LEN);

  logic [RW-1:0] left_q, left_d;
  logic          rst_n_q, flag_q;

  always_comb begin
    if (fire_i)            left_d = LEN;
    else if (left_q != '0) left_d = left_q - RW'(1);
    else                   left_d = '0;
  end

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      left_q  <= '0;
      rst_n_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      left_q  <= left_d;
      rst_n_q <= (left_d == '0);
      if (fire_i)          flag_q <= 1'b1;
      else if (stat_clr_i) flag_q <= 1'b0;
    end
  end

  assign rst_n_o = rst_n_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 16'hFFFF,
  parameter int PRE_W   = 13,
  parameter int CLR_LSB = 4,
  parameter int CNT_W   = 6,
  parameter int TERM    = 32,
  parameter int RST_LEN = 32
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              rst_i,
  input  logic              wd_dis_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] vec_lo_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              stat_clr_i,
  output logic              wd_rst_n_o,
  output logic              wd_flag_o
);
  bus_evt_t         evt;
  logic             clr_w, tick_w, timeout_w;
  logic [PRE_W-1:0] pre_w;
  logic [CNT_W-1:0] cnt_w;

  assign clr_w = por_i | rst_i;

  wdog_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR)) dec_i (
    .clk_i(clk_i), .clr_i(clr_w), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
    .rd_i(bus_rd_i), .vec_lo_i(vec_lo_i), .evt_o(evt), .rd_data_o(rd_data_o)
  );

  wdog_prescaler #(.PRE_W(PRE_W), .CLR_LSB(CLR_LSB)) pre_i (
    .clk_i(clk_i), .clr_i(clr_w), .stop_i(stop_i), .svc_i(evt.svc),
    .tick_o(tick_w), .pre_o(pre_w)
  );

  wdog_counter #(.CNT_W(CNT_W), .TERM(TERM)) cnt_i (
    .clk_i(clk_i), .clr_i(clr_w), .svc_i(evt.svc), .tick_i(tick_w),
    .dis_i(wd_dis_i), .timeout_o(timeout_w), .cnt_o(cnt_w)
  );

  wdog_rst_pulse #(.RST_LEN(RST_LEN)) pls_i (
    .clk_i(clk_i), .por_i(por_i), .fire_i(timeout_w), .stat_clr_i(stat_clr_i),
    .rst_n_o(wd_rst_n_o), .flag_o(wd_flag_o)
  );
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int PRE_W   = 13,
  parameter int CNT_W   = 6,
  parameter int RST_LEN = 32
) (
  input logic             clk_i,
  input logic             por_i,
  input logic             rst_i,
  input logic             wd_dis_i,
  input logic             stop_i,
  input logic             svc,
  input logic [PRE_W-1:0] pre,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_n,
  input logic             flag
);
  localparam int LW = $clog2(RST_LEN + 2);
  logic [LW-1:0] low_run;

  always_ff @(posedge clk_i) begin
    if (por_i || rst_n)               low_run <= '0;
    else if (low_run != LW'(RST_LEN + 1)) low_run <= low_run + LW'(1);
  end

  a_r3_svc_clears: assert property (@(posedge clk_i) disable iff (por_i)
    svc |=> (cnt == '0));

  a_r5_pulse_len: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(rst_n) |-> (low_run == LW'(RST_LEN)));

  a_r5_no_overrun: assert property (@(posedge clk_i) disable iff (por_i)
    (low_run <= LW'(RST_LEN)));

  a_r6_flag_with_pulse: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(rst_n) |-> flag);

  a_r7_dis_freezes: assert property (@(posedge clk_i) disable iff (por_i)
    (wd_dis_i && !svc && !rst_i) |=> $stable(cnt));

  a_r8_stop_holds: assert property (@(posedge clk_i) disable iff (por_i)
    (stop_i && !svc && !rst_i) |=> ($stable(cnt) && (pre == '0)));

  a_r9_rst_clears: assert property (@(posedge clk_i) disable iff (por_i)
    rst_i |=> ((cnt == '0) && (pre == '0)));

  a_r10_svc_wins: assert property (@(posedge clk_i) disable iff (por_i)
    (svc && rst_n) |=> rst_n);
endmodule

bind wdog_guard wdog_guard_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W), .RST_LEN(RST_LEN)) chk_i (
  .clk_i(clk_i), .por_i(por_i), .rst_i(rst_i), .wd_dis_i(wd_dis_i), .stop_i(stop_i),
  .svc(evt.svc), .pre(pre_w), .cnt(cnt_w), .rst_n(wd_rst_n_o), .flag(wd_flag_o)
);

// File: tb/wdog_guard_tb.sv
`timescale 1ns/1ps
module wdog_guard_tb_top;
  localparam int ADDR_W = 16, DATA_W = 8, PRE_W = 5, CLR_LSB = 2;
  localparam int CNT_W = 6, TERM = 4, RST_LEN = 6;
  localparam logic [ADDR_W-1:0] SVC = 16'hFFFF;
  localparam int PERIOD = TERM << PRE_W;

  logic clk = 0, por = 1, rst = 0, dis = 0, stop = 0, wr = 0, rd = 0, sclr = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] vec = '0, rdata;
  logic rst_n, flag;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  wdog_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC), .PRE_W(PRE_W),
    .CLR_LSB(CLR_LSB), .CNT_W(CNT_W), .TERM(TERM), .RST_LEN(RST_LEN)) dut_i (
    .clk_i(clk), .por_i(por), .rst_i(rst), .wd_dis_i(dis), .stop_i(stop),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .vec_lo_i(vec),
    .rd_data_o(rdata), .stat_clr_i(sclr), .wd_rst_n_o(rst_n), .wd_flag_o(flag));

  // reference model written from the requirements
  int m_p = 0, m_c = 0, m_r = 0;
  logic m_rst_n = 1, m_flag = 0;
  logic [DATA_W-1:0] m_rd = '0;
  always @(posedge clk) begin
    bit svc, fire;
    svc = wr && (addr == SVC);
    fire = 0;
    if (por) begin
      m_p = 0; m_c = 0; m_r = 0; m_rst_n = 1; m_flag = 0; m_rd = '0;
    end else begin
      if (rst) begin
        m_p = 0; m_c = 0; m_rd = '0;
      end else begin
        m_rd = (rd && addr == SVC) ? vec : '0;
        if (!stop && m_p == (1 << PRE_W) - 1 && !dis && !svc && m_c == TERM - 1) fire = 1;
        if (svc) m_c = 0;
        else if (!stop && m_p == (1 << PRE_W) - 1 && !dis) m_c = (m_c == TERM - 1) ? 0 : m_c + 1;
        if (stop) m_p = 0;
        else if (svc) m_p = (m_p + 1) % (1 << CLR_LSB);
        else m_p = (m_p + 1) % (1 << PRE_W);
      end
      if (fire) m_r = RST_LEN; else if (m_r > 0) m_r = m_r - 1;
      m_rst_n = (m_r == 0);
      if (fire) m_flag = 1; else if (sclr) m_flag = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance one clock, then compare all outputs against the model
  task automatic nx();
    @(negedge clk);
    chk(rst_n == m_rst_n, "R5 reset output", rst_n, m_rst_n);
    chk(flag == m_flag, "R6 cause flag", flag, m_flag);
    chk(rdata == m_rd, "R4 read data", rdata, m_rd);
  endtask

  task automatic until_low(output int n);
    n = 0;
    do begin nx(); n++; end while (rst_n && n < 4 * PERIOD);
  endtask

  task automatic pulse_rst();
    rst = 1; nx(); rst = 0;
  endtask

  function automatic int gap_after_svc(input int low_bits);
    return ((1 << PRE_W) - low_bits) + (TERM - 1) * (1 << PRE_W);
  endfunction

  initial begin : wd
    #(200000 * 5);
    total++; fails++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n, len, l;
    void'($urandom(32'd4711));
    repeat (3) nx();
    chk(rst_n == 1 && flag == 0 && rdata == 0, "R9 por state", {rst_n, flag}, 2);
    por = 0;

    // R1/R2: free-running timeout after reset
    until_low(n);
    chk(n == PERIOD, "R2 timeout distance", n, PERIOD);
    len = 0;
    while (!rst_n && len < 4 * RST_LEN) begin nx(); len++; end
    chk(len == RST_LEN, "R5 pulse length", len, RST_LEN);
    chk(flag == 1, "R6 flag set", flag, 1);
    sclr = 1; nx(); sclr = 0;
    chk(flag == 0, "R6 flag cleared", flag, 0);

    // R4/R3/R9: reads and foreign writes leave timing alone
    pulse_rst();
    n = 0;
    do begin
      if (n == 10) begin rd = 1; addr = SVC; vec = 8'h5A; end
      else if (n == 11) begin
        rd = 0; chk(rdata == 8'h5A, "R4 vector byte", rdata, 8'h5A);
        rd = 1; addr = SVC - 1;
      end else if (n == 12) begin
        rd = 0; chk(rdata == 0, "R4 other read", rdata, 0);
        wr = 1; addr = SVC - 1;
      end else wr = 0;
      nx(); n++;
    end while (rst_n && n < 4 * PERIOD);
    wr = 0; rd = 0;
    chk(n == PERIOD, "R3 foreign write ignored, R4 read no effect", n, PERIOD);
    repeat (RST_LEN + 1) nx();
    pulse_rst();
    chk(flag == 1, "R9 flag survives rst_i", flag, 1);

    // R3: service mid-count restarts the period, low bits kept
    repeat (100) nx();
    wr = 1; addr = SVC; nx(); wr = 0;
    l = m_p;
    chk(l == (100 + 1) % (1 << CLR_LSB), "R3 low bits kept", l, (101 % (1 << CLR_LSB)));
    until_low(n);
    chk(n == gap_after_svc(l), "R3 service restarts", n, gap_after_svc(l));
    repeat (RST_LEN + 1) nx();

    // R7: disabled watchdog never fires
    pulse_rst();
    dis = 1;
    repeat (5 * PERIOD) nx();
    chk(rst_n == 1, "R7 disabled no timeout", rst_n, 1);
    dis = 0;

    // R8: stop holds count, clears prescaler
    pulse_rst();
    repeat (2 << PRE_W) nx();
    stop = 1; repeat (100) nx(); stop = 0;
    until_low(n);
    chk(n == PERIOD - (2 << PRE_W), "R8 resume after stop", n, PERIOD - (2 << PRE_W));
    repeat (RST_LEN + 1) nx();

    // R10: service on the final tick wins
    sclr = 1; pulse_rst(); sclr = 0;
    while (!(m_c == TERM - 1 && m_p == (1 << PRE_W) - 1)) nx();
    wr = 1; addr = SVC; nx(); wr = 0;
    l = m_p;
    repeat (RST_LEN + 2) nx();
    chk(rst_n == 1 && flag == 0, "R10 service beats timeout", {rst_n, flag}, 2);
    until_low(n);
    chk(n + RST_LEN + 2 == gap_after_svc(l), "R10 next period", n + RST_LEN + 2, gap_after_svc(l));

    // random mix, compared cycle by cycle against the model (R1..R10)
    for (int i = 0; i < 6000; i++) begin
      rst  = ($urandom_range(499) == 0);
      wr   = ($urandom_range(149) == 0);
      rd   = ($urandom_range(3) == 0);
      addr = ($urandom_range(1) == 0) ? SVC : ADDR_W'($urandom);
      vec  = DATA_W'($urandom);
      sclr = ($urandom_range(99) == 0);
      if ($urandom_range(299) == 0) dis = ~dis;
      if ($urandom_range(199) == 0) stop = ~stop;
      nx();
    end

    disable wd;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule